// File: doc/BRIEF.md
# Programmable SPI Command Transaction Engine

This engine runs one SPI transaction that software composes in a set of configuration words. When it sees a start pulse, it captures the configuration, command, address and write-data words. It then clocks out up to five optional phases in a fixed sequence: a single opcode byte, an address of up to four bytes, up to 31 write bytes, a run of dummy bytes, and up to 31 read bytes. Bytes that arrive during the read phase are stored into a bank of 32-bit read words. When the last phase ends, the engine drops its busy flag and raises a sticky ready flag. If the ready flag is enabled, it also raises an interrupt.

The dummy phase does not send zeros. Each dummy byte takes a pattern from the upper bytes of the command word. That byte is sent in chunks of 1, 2, 4 or 8 bits per clock, on the low data lines. When a count goes past the capacity of the data words, the extra write bytes reuse the last write word and the extra read bytes are clocked and then dropped. The engine asserts and releases the selected chip select around the transaction only in automatic mode. In manual mode the selected device stays selected.

Top module: `spi_xact_engine`

## Requirements
- R1: Phases always run in the order opcode, address, write, dummy, read. A phase whose count is zero produces no clock pulses. A configuration with every count at zero completes with no pulses.
- R2: The opcode phase runs only when cfg[10] is 1. It sends cmd[7:0].
- R3: The address byte count is cfg[13:11]. Values 0 to 4 send that many low bytes of addr, most significant byte first. Values 5 to 7 send no address bytes.
- R4: The write byte count is cfg[20:16]. Byte i with i < 16 is wdata[8*i+7:8*i]. Byte i with i >= 16 reuses the last word, lane i mod 4, which is wdata[96+8*(i%4)+7 : 96+8*(i%4)].
- R5: The dummy byte count is cfg[23:21]. Dummy byte 0 is cmd[15:8], dummy byte 1 is cmd[23:16], and every later dummy byte is cmd[31:24].
- R6: One clock pulse is one clk cycle with spi_sck low, then one with spi_sck high. spi_dq changes only while spi_sck is low. Opcode, address, write and read bytes go out MSB first on spi_dq[0], with spi_dq[7:1] at 0; during the read phase spi_dq[0] is also 0. Dummy bytes go out 2^cfg[7:6] bits per pulse, lowest chunk first, with the chunk's lowest bit on spi_dq[0].
- R7: The read byte count is cfg[28:24]. miso is sampled at the end of each high cycle, MSB first. Read byte i goes to rd_data[8*i+7:8*i] when i < 16. Later read bytes are clocked but discarded. Lanes that are not written keep their earlier value.
- R8: busy rises on the clock after a start while idle. A start while busy is ignored. When the transaction ends, busy falls and rdy sets on the same clock. rdy stays set until a rdy_clr pulse.
- R9: When auto_cs is 1 at start, spi_cs_n[cs_sel] is low from the first pulse until the cycle after busy falls, and all spi_cs_n bits are high when idle. When auto_cs is 0, spi_cs_n[cs_sel] is held low continuously. At most one chip select is low at any time.
- R10: irq equals rdy AND rdy_ie, registered one clock edge after either changes.
- R11: After reset, busy, rdy, irq, spi_sck, spi_dq and rd_data are 0 and spi_cs_n is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a transaction |
| cfg | input | 32 | Phase counts, opcode enable and dummy bits-per-clock |
| cmd | input | 32 | Opcode byte and dummy patterns |
| addr | input | 32 | Address bytes |
| wdata | input | 128 | Four write words |
| auto_cs | input | 1 | 1: engine frames chip select; 0: chip select held low |
| cs_sel | input | 2 | Chip select index |
| rdy_ie | input | 1 | Ready interrupt enable |
| rdy_clr | input | 1 | Clears the ready flag |
| miso | input | 1 | Serial data from device |
| busy | output | 1 | Transaction in progress |
| rdy | output | 1 | Sticky completion flag |
| irq | output | 1 | Ready interrupt |
| rd_data | output | 128 | Four read words |
| spi_sck | output | 1 | Serial clock |
| spi_dq | output | 8 | Data lines, lane 0 is MOSI |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that start, rdy_clr and the configuration inputs are driven synchronously to clk. They also assume that the device on miso changes its bit only after a falling edge of spi_sck. The bench meets the second assumption by deriving miso from a counter of falling spi_sck edges. It changes every input only on the falling clk edge and never alters cs_sel while a transaction is running. Because of that, the chip select checks see a stable selection.

// File: rtl/sx_pkg.sv
package sx_pkg;

  typedef enum logic [2:0] {
    PH_CMD = 3'd0,
    PH_ADR = 3'd1,
    PH_WR  = 3'd2,
    PH_DUM = 3'd3,
    PH_RD  = 3'd4,
    PH_END = 3'd5
  } phase_t;

  // Configuration field positions decoded by this engine
  localparam int CF_CMD_EN = 10;
  localparam int CF_ADR_LO = 11;
  localparam int CF_WR_LO  = 16;
  localparam int CF_DUM_LO = 21;
  localparam int CF_RD_LO  = 24;
  localparam int CF_BPC_LO = 6;

  function automatic logic [5:0] phase_count(phase_t p, logic [31:0] cfg);
    logic [5:0] n;
    case (p)
      PH_CMD:  n = {5'd0, cfg[CF_CMD_EN]};
      PH_ADR:  n = (cfg[CF_ADR_LO +: 3] > 3'd4) ? 6'd0 : {3'd0, cfg[CF_ADR_LO +: 3]};
      PH_WR:   n = {1'b0, cfg[CF_WR_LO +: 5]};
      PH_DUM:  n = {3'd0, cfg[CF_DUM_LO +: 3]};
      PH_RD:   n = {1'b0, cfg[CF_RD_LO +: 5]};
      default: n = 6'd0;
    endcase
    return n;
  endfunction

  // Lowest phase at or after 'from' that has a nonzero count
  function automatic phase_t first_live(phase_t from, logic [31:0] cfg);
    phase_t r;
    r = PH_END;
    for (int k = 4; k >= 0; k--) begin
      if (k >= int'(from) && phase_count(phase_t'(k), cfg) != 6'd0) r = phase_t'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/sx_seq.sv
module sx_seq import sx_pkg::*; #(
  parameter int WR_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [31:0]           cfg_i,
  input  logic [31:0]           cmd_i,
  input  logic [31:0]           addr_i,
  input  logic [32*WR_WORDS-1:0] wdata_i,
  input  logic                  adv,
  output phase_t                phase_o,
  output logic [4:0]            idx_o,
  output logic [7:0]            byte_o,
  output logic [1:0]            dbpc_o
);
  localparam int WR_BYTES = 4 * WR_WORDS;

  logic [31:0]           cfg_q, cmd_q, addr_q;
  logic [32*WR_WORDS-1:0] wdata_q;
  phase_t                phase_q;
  logic [4:0]            idx_q;
  logic [5:0]            count_cur;

  assign count_cur = phase_count(phase_q, cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      phase_q <= PH_END;
      idx_q   <= '0;
    end else if (go) begin
      cfg_q   <= cfg_i;
      cmd_q   <= cmd_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      phase_q <= first_live(PH_CMD, cfg_i);
      idx_q   <= '0;
    end else if (adv && phase_q != PH_END) begin
      if ({1'b0, idx_q} + 6'd1 < count_cur) begin
        idx_q <= idx_q + 5'd1;
      end else begin
        idx_q   <= '0;
        phase_q <= (phase_q == PH_RD) ? PH_END : first_live(phase_t'(phase_q + 3'd1), cfg_q);
      end
    end
  end

  always_comb begin
    int sel;
    sel    = 0;
    byte_o = '0;
    case (phase_q)
      PH_CMD: byte_o = cmd_q[7:0];
      PH_ADR: begin
        sel    = int'(count_cur) - 1 - int'(idx_q);
        byte_o = 8'(addr_q >> (8 * sel));
      end
      PH_WR: begin
        sel    = (int'(idx_q) < WR_BYTES) ? int'(idx_q) : (WR_BYTES - 4 + int'(idx_q[1:0]));
        byte_o = 8'(wdata_q >> (8 * sel));
      end
      PH_DUM: begin
        case (idx_q)
          5'd0:    byte_o = cmd_q[15:8];
          5'd1:    byte_o = cmd_q[23:16];
          default: byte_o = cmd_q[31:24];
        endcase
      end
      default: byte_o = '0;
    endcase
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign dbpc_o  = cfg_q[CF_BPC_LO +: 2];

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    !go |=> phase_q >= $past(phase_q)) else $error("phase went backwards"); // R1

endmodule

// File: rtl/sx_shift.sv
module sx_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_i,
  input  logic [1:0] wlog_i,
  input  logic       lsb_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic [7:0] dq_o
);
  logic [7:0] sh_q, rx_q, dq_q, sh_nxt;
  logic [2:0] left_q;
  logic [1:0] wl_q;
  logic       lsb_q, half_q, busy_q, done_q;

  function automatic logic [7:0] chunk_of(logic [7:0] s, logic [1:0] wl, logic lsbf);
    logic [7:0] m;
    case (wl)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return lsbf ? (s & m) : {7'd0, s[7]};
  endfunction

  function automatic logic [7:0] shift_on(logic [7:0] s, logic [1:0] wl, logic lsbf);
    logic [7:0] r;
    if (!lsbf) r = {s[6:0], 1'b0};
    else begin
      case (wl)
        2'd0:    r = s >> 1;
        2'd1:    r = s >> 2;
        2'd2:    r = s >> 4;
        default: r = 8'h00;
      endcase
    end
    return r;
  endfunction

  assign sh_nxt = shift_on(sh_q, wl_q, lsb_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0; rx_q <= '0; dq_q <= '0; left_q <= '0; wl_q <= '0;
      lsb_q <= 1'b0; half_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load && !busy_q) begin
        sh_q   <= byte_i;
        wl_q   <= wlog_i;
        lsb_q  <= lsb_i;
        left_q <= lsb_i ? (3'd7 >> wlog_i) : 3'd7;
        half_q <= 1'b0;
        busy_q <= 1'b1;
        dq_q   <= chunk_of(byte_i, wlog_i, lsb_i);
      end else if (busy_q && !half_q) begin
        half_q <= 1'b1;
      end else if (busy_q) begin
        half_q <= 1'b0;
        rx_q   <= {rx_q[6:0], miso_i};
        if (left_q == 3'd0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          dq_q   <= '0;
        end else begin
          left_q <= left_q - 3'd1;
          sh_q   <= sh_nxt;
          dq_q   <= chunk_of(sh_nxt, wl_q, lsb_q);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = half_q;
  assign dq_o   = dq_q;

  AST_SCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sck_o |=> !sck_o) else $error("sck high too long"); // R6
  AST_DQ_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> $stable(dq_o)) else $error("data moved while sck high"); // R6

endmodule

// File: rtl/sx_rdbuf.sv
module sx_rdbuf #(
  parameter int RD_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [4:0]             idx,
  input  logic [7:0]             byte_i,
  output logic [32*RD_WORDS-1:0] data_o
);
  localparam int RD_BYTES = 4 * RD_WORDS;

  for (genvar b = 0; b < RD_BYTES; b++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && idx == 5'(b)) q <= byte_i;
    end
    assign data_o[8*b +: 8] = q;
  end

  AST_DISCARD_EXCESS: assert property (@(posedge clk) disable iff (rst)
    (we && int'(idx) >= RD_BYTES) |=> $stable(data_o)) else $error("excess byte stored"); // R7

endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine import sx_pkg::*; #(
  parameter int NCS      = 4,
  parameter int WR_WORDS = 4,
  parameter int RD_WORDS = 4,
  localparam int CSW     = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [31:0]            cfg,
  input  logic [31:0]            cmd,
  input  logic [31:0]            addr,
  input  logic [32*WR_WORDS-1:0] wdata,
  input  logic                   auto_cs,
  input  logic [CSW-1:0]         cs_sel,
  input  logic                   rdy_ie,
  input  logic                   rdy_clr,
  input  logic                   miso,
  output logic                   busy,
  output logic                   rdy,
  output logic                   irq,
  output logic [32*RD_WORDS-1:0] rd_data,
  output logic                   spi_sck,
  output logic [7:0]             spi_dq,
  output logic [NCS-1:0]         spi_cs_n
);
  logic           run_q, rdy_q, irq_q, auto_q;
  logic [CSW-1:0] sel_q;
  logic [NCS-1:0] cs_n_q, sel_hot;
  logic           go, load, fin, rdy_d;
  phase_t         phase;
  logic [4:0]     idx;
  logic [7:0]     tx_byte, rx_byte;
  logic [1:0]     dbpc;
  logic           sh_busy, sh_done;
  logic           act_auto;
  logic [CSW-1:0] act_sel;

  assign go    = start && !run_q;
  assign load  = run_q && !sh_busy && !sh_done && (phase != PH_END);
  assign fin   = run_q && !sh_busy && !sh_done && (phase == PH_END);
  assign rdy_d = fin ? 1'b1 : (rdy_clr ? 1'b0 : rdy_q);

  assign act_auto = run_q ? auto_q : auto_cs;
  assign act_sel  = run_q ? sel_q : cs_sel;

  always_comb begin
    for (int i = 0; i < NCS; i++) sel_hot[i] = (act_sel == CSW'(i));
  end

  sx_seq #(.WR_WORDS(WR_WORDS)) u_seq (
    .clk(clk), .rst(rst), .go(go), .cfg_i(cfg), .cmd_i(cmd), .addr_i(addr),
    .wdata_i(wdata), .adv(sh_done), .phase_o(phase), .idx_o(idx),
    .byte_o(tx_byte), .dbpc_o(dbpc)
  );

  sx_shift u_shift (
    .clk(clk), .rst(rst), .load(load), .byte_i(tx_byte),
    .wlog_i((phase == PH_DUM) ? dbpc : 2'd0), .lsb_i(phase == PH_DUM),
    .miso_i(miso), .busy_o(sh_busy), .done_o(sh_done), .rx_o(rx_byte),
    .sck_o(spi_sck), .dq_o(spi_dq)
  );

  sx_rdbuf #(.RD_WORDS(RD_WORDS)) u_rdbuf (
    .clk(clk), .rst(rst), .we(sh_done && phase == PH_RD), .idx(idx),
    .byte_i(rx_byte), .data_o(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      irq_q  <= 1'b0;
      auto_q <= 1'b1;
      sel_q  <= '0;
      cs_n_q <= '1;
    end else begin
      if (go) begin
        run_q  <= 1'b1;
        auto_q <= auto_cs;
        sel_q  <= cs_sel;
      end else if (fin) begin
        run_q <= 1'b0;
      end
      rdy_q  <= rdy_d;
      irq_q  <= rdy_d & rdy_ie;
      cs_n_q <= (!act_auto || run_q) ? ~sel_hot : '1;
    end
  end

  assign busy     = run_q;
  assign rdy      = rdy_q;
  assign irq      = irq_q;
  assign spi_cs_n = cs_n_q;

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy) else $error("start not taken"); // R8
  AST_END_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rdy) else $error("finish without ready"); // R8
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n)) else $error("several chip selects"); // R9
  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sck |-> !(&spi_cs_n)) else $error("clock with no device"); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rdy && $past(rdy_ie))) else $error("spurious irq"); // R10

endmodule

// File: tb/sim_spi_xact_engine.sv
module sim_spi_xact_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [95:0] VECS [NV] = '{
    {32'h00000400, 32'h0000009F, 32'h00000000},
    {32'h04001C00, 32'h00000003, 32'h00ABCDEF},
    {32'h00142400, 32'h00000002, 32'h12345678},
    {32'h02600040, 32'hC3A55A00, 32'h00000000},
    {32'h14400080, 32'h0081E700, 32'h00000000},
    {32'h012034C0, 32'h0000B60B, 32'hFFFFFFFF},
    {32'h00000000, 32'h00000000, 32'h00000000},
    {32'h03221400, 32'h00007E3B, 32'h0000BEEF}
  };

  logic clk = 0, rst = 1, start = 0, auto_cs = 1, rdy_ie = 0, rdy_clr = 0;
  logic [31:0] cfg = 0, cmd = 0, addr = 0;
  logic [127:0] wdata;
  logic [1:0] cs_sel = 0;
  logic miso, busy, rdy, irq, spi_sck;
  logic [127:0] rd_data;
  logic [7:0] spi_dq;
  logic [3:0] spi_cs_n;

  int tests = 0, fails = 0;
  int pulses = 0, mcnt = 0, cs_bad = 0, mbase = 0;
  logic [7:0] got [0:1023];
  logic [7:0] expv [0:1023];
  logic [7:0] mrd [0:15];
  int n_exp, rstart;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xact_engine u0 (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .cmd(cmd), .addr(addr),
    .wdata(wdata), .auto_cs(auto_cs), .cs_sel(cs_sel), .rdy_ie(rdy_ie),
    .rdy_clr(rdy_clr), .miso(miso), .busy(busy), .rdy(rdy), .irq(irq),
    .rd_data(rd_data), .spi_sck(spi_sck), .spi_dq(spi_dq), .spi_cs_n(spi_cs_n)
  );

  function automatic logic mbit(int k);
    return ((k * 13 + 7) % 11) > 5;
  endfunction

  assign miso = mbit(mcnt - mbase);

  always @(posedge spi_sck) begin
    got[pulses % 1024] = spi_dq;
    if (spi_cs_n[cs_sel] !== 1'b0) cs_bad++;
    pulses++;
  end
  always @(negedge spi_sck) mcnt++;

  function automatic logic [7:0] wbyte(int i);
    int k;
    k = (i < 16) ? i : 12 + (i % 4);
    return wdata[8*k +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    expv[n_exp] = v;
    n_exp++;
  endtask

  task automatic push_msb(input logic [7:0] b);
    for (int t = 7; t >= 0; t--) push({7'd0, b[t]});
  endtask

  task automatic build(input logic [31:0] c, input logic [31:0] op, input logic [31:0] ad);
    int na, w;
    logic [7:0] b;
    n_exp = 0;
    if (c[10]) push_msb(op[7:0]);
    na = int'(c[13:11]);
    if (na <= 4) for (int i = na - 1; i >= 0; i--) push_msb(ad[8*i +: 8]);
    for (int i = 0; i < int'(c[20:16]); i++) push_msb(wbyte(i));
    w = 1 << c[7:6];
    for (int d = 0; d < int'(c[23:21]); d++) begin
      b = (d == 0) ? op[15:8] : (d == 1) ? op[23:16] : op[31:24];
      for (int ch = 0; ch < 8 / w; ch++) push(8'((b >> (ch * w)) & ((1 << w) - 1)));
    end
    rstart = n_exp;
    for (int j = 0; j < int'(c[28:24]); j++) begin
      b = 0;
      for (int t = 0; t < 8; t++) begin
        b = {b[6:0], mbit(rstart + 8*j + t)};
        push(8'h00);
      end
      if (j < 16) mrd[j] = b;
    end
  endtask

  function automatic logic [127:0] model_rd();
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[8*j +: 8] = mrd[j];
    return r;
  endfunction

  task automatic run_vec(input logic [31:0] c, input logic [31:0] op, input logic [31:0] ad,
                         input logic au, input logic [1:0] sl, input int restart_at, input string tag);
    int pbase, csb, mism, cyc;
    @(negedge clk);
    cfg = c; cmd = op; addr = ad; auto_cs = au; cs_sel = sl;
    pbase = pulses; mbase = mcnt; csb = cs_bad;
    build(c, op, ad);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (busy && cyc < 20000) begin
      if (restart_at > 0 && cyc == restart_at) begin cfg = 32'h14400080; start = 1; end
      if (restart_at > 0 && cyc == restart_at + 1) start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    @(negedge clk);
    chk(pulses - pbase == n_exp, tag, "pulse count", 128'(pulses - pbase), 128'(n_exp));
    mism = 0;
    for (int k = 0; k < n_exp && k < pulses - pbase; k++)
      if (got[(pbase + k) % 1024] !== expv[k]) mism++;
    chk(mism == 0, tag, "data lane mismatches", 128'(mism), 128'd0);
    chk(rd_data === model_rd(), "R7", "read words", rd_data, model_rd());
    chk(rdy === 1'b1 && busy === 1'b0, "R8", "rdy/busy after end", {rdy, busy}, 2'b10);
    chk(cs_bad == csb, "R9", "cs low during pulses", 128'(cs_bad - csb), 128'd0);
    chk(spi_cs_n === (au ? 4'b1111 : ~(4'b0001 << sl)), "R9", "idle chip select",
        spi_cs_n, au ? 4'b1111 : ~(4'b0001 << sl));
  endtask

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5: return "R6";
      6: return "R1";
      default: return "R1";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wdata[8*i +: 8] = 8'(8'h30 + i * 7);
    for (int j = 0; j < 16; j++) mrd[j] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(busy === 0 && rdy === 0 && irq === 0, "R11", "flags after reset", {busy, rdy, irq}, 3'b000);
    chk(spi_sck === 0 && spi_dq === 8'h00, "R11", "bus after reset", {spi_sck, spi_dq}, 9'd0);
    chk(rd_data === 128'd0, "R11", "read words after reset", rd_data, 128'd0);
    chk(spi_cs_n === 4'b1111, "R11", "cs after reset", spi_cs_n, 4'b1111);

    for (int i = 0; i < NV; i++)
      run_vec(VECS[i][95:64], VECS[i][63:32], VECS[i][31:0], 1'b1, 2'(i % 4), 0, tag_of(i));

    // R10 interrupt follows rdy and enable
    @(negedge clk); rdy_ie = 1;
    @(negedge clk);
    chk(irq === 1'b1, "R10", "irq with rdy and enable", irq, 1'b1);
    rdy_ie = 0;
    @(negedge clk);
    chk(irq === 1'b0, "R10", "irq masked", irq, 1'b0);
    rdy_ie = 1;
    @(negedge clk);
    rdy_clr = 1;
    @(negedge clk);
    rdy_clr = 0;
    chk(rdy === 1'b0, "R8", "rdy cleared", rdy, 1'b0);
    chk(irq === 1'b0, "R10", "irq after clear", irq, 1'b0);
    rdy_ie = 0;

    // R8 start while busy is ignored: pulse count must match the first transaction
    run_vec(32'h00142400, 32'h00000002, 32'h12345678, 1'b1, 2'd1, 40, "R8");

    // R9 manual chip select stays low before and after
    @(negedge clk); auto_cs = 0; cs_sel = 2;
    @(negedge clk); @(negedge clk);
    chk(spi_cs_n === 4'b1011, "R9", "manual cs before run", spi_cs_n, 4'b1011);
    run_vec(32'h00000400, 32'h000000A5, 32'h0, 1'b0, 2'd2, 0, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule